// File: doc/BRIEF.md
# Triggered Digitization Scheduler

This block sits between an analog sample pipeline and a shared converter. When an event-accept trigger arrives, it receives the pipeline slot that holds the event and a hit mask of channels that fired their discriminator. If the converter is idle and no event is waiting, the event starts at once. Otherwise the event is held in a four-entry pending buffer and served in arrival order. Triggers can come much faster than one digitization takes, so the buffer absorbs short bursts. A trigger that finds the buffer full is dropped, and a sticky flag records the loss.

For each event the scheduler walks the channels upward from channel 0. It stops after the highest channel set in the hit mask, so the length of a pass depends on the event. Each channel is requested from the converter through a request/done handshake. The returned charge is compared with a programmable threshold, and the channel is kept only if the charge reaches it. Every kept channel leaves on a valid/ready stream as a word holding the channel, charge and time. Each event closes with a trailer word that carries the number of bytes the event produced.

Top module: `digi_sched`

## Requirements
- R1: A trigger taken while no event is being digitized and the pending buffer is empty starts that event on the next cycle. For a non-zero hit mask, `conv_req_o` is then high with `conv_slot_o` equal to the trigger slot and `conv_chan_o` equal to 0.
- R2: A trigger that arrives while an event is being digitized, or while the buffer still holds events, is stored. Up to four such events are held, and none of them is lost.
- R3: Events are digitized and streamed in the order their triggers arrived. Every output word of an event carries that event's slot on `out_slot_o`.
- R4: A trigger that arrives while four events are pending and none leaves in that cycle is discarded. `overflow_o` then goes to 1 and stays at 1 until reset.
- R5: For one event, the converter is asked for channels 0, 1, 2 and upward without gaps. The last channel asked for is the highest set bit of the hit mask, and no channel above it is asked for.
- R6: A converted channel is streamed when its charge, taken as unsigned, is greater than or equal to `thr_i`. Otherwise it is suppressed, so a charge equal to the threshold is kept.
- R7: A data word has `out_last_o` at 0 and carries the channel number, charge and time returned by the converter for that channel. Its `out_bytes_o` is 0.
- R8: Each event ends with exactly one trailer word. It has `out_last_o` at 1, channel, charge and time fields at 0, and `out_bytes_o` equal to 2 times the number of data words of that event. An event with an all-zero hit mask requests no conversion and produces only a trailer with 0 bytes.
- R9: While `out_valid_o` is 1 and `out_ready_i` is 0, the output word and `out_valid_o` hold their values.
- R10: While reset is held, `out_valid_o`, `conv_req_o` and `overflow_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Event-accept trigger, one cycle per event |
| trig_slot_i | input | SLOT_W | Pipeline slot of the triggered event |
| trig_hits_i | input | N_CH | Discriminator hit mask of the event |
| thr_i | input | CHG_W | Charge threshold |
| conv_req_o | output | 1 | Conversion request, held until done |
| conv_slot_o | output | SLOT_W | Slot being converted |
| conv_chan_o | output | CH_W | Channel being converted |
| conv_done_i | input | 1 | Conversion result valid, one cycle |
| conv_charge_i | input | CHG_W | Converted charge |
| conv_time_i | input | TIM_W | Converted time |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | Downstream accepts word |
| out_slot_o | output | SLOT_W | Slot of the event |
| out_chan_o | output | CH_W | Channel number (0 on trailer) |
| out_charge_o | output | CHG_W | Charge (0 on trailer) |
| out_time_o | output | TIM_W | Time (0 on trailer) |
| out_last_o | output | 1 | Trailer marker |
| out_bytes_o | output | BYTE_W | Event byte count, on trailer only |
| overflow_o | output | 1 | Sticky lost-trigger flag |

## Verification
The hardest case to reach is a full pending buffer. Normally the running event drains it too soon: each event completes and the next one is popped before a fifth trigger can arrive. To get there, the bench holds `out_ready_i` low so that the first event stalls on its output. It then issues bursts of back-to-back triggers, five of them to fill the buffer exactly and seven to overflow it. The bench predicts which triggers survive and checks the order of the streamed events, the conversion order and the sticky flag.

// File: rtl/digi_pkg.sv
package digi_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_EMIT  = 2'd2,
    ST_TRAIL = 2'd3
  } scan_state_e;
endpackage

// File: rtl/pend_fifo.sv
module pend_fifo #(
  parameter int W     = 13,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] ptr_inc(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign dout_o  = mem_q[rd_q];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  mem_q[g] <= '0;
      else if (push_i && wr_q == PTR_W'(g))         mem_q[g] <= din_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= ptr_inc(wr_q);
      if (pop_i)  rd_q <= ptr_inc(rd_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R2
  no_push_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !pop_i |-> !full_o);
  // R3
  no_pop_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/last_hit.sv
module last_hit #(
  parameter int N_CH = 8,
  parameter int CH_W = 3
) (
  input  logic [N_CH-1:0] hits_i,
  output logic            any_o,
  output logic [CH_W-1:0] last_o
);
  always_comb begin
    last_o = '0;
    for (int i = 0; i < N_CH; i++) begin
      if (hits_i[i]) last_o = CH_W'(i);
    end
    any_o = |hits_i;
  end
endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import digi_pkg::*;
#(
  parameter int N_CH   = 8,
  parameter int CH_W   = 3,
  parameter int SLOT_W = 5,
  parameter int CHG_W  = 8,
  parameter int TIM_W  = 8,
  parameter int BYTE_W = 5,
  parameter int BPH    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic              any_i,
  input  logic [CH_W-1:0]   last_i,
  input  logic [CHG_W-1:0]  thr_i,
  output logic              busy_o,
  output logic              conv_req_o,
  output logic [SLOT_W-1:0] conv_slot_o,
  output logic [CH_W-1:0]   conv_chan_o,
  input  logic              conv_done_i,
  input  logic [CHG_W-1:0]  conv_charge_i,
  input  logic [TIM_W-1:0]  conv_time_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [SLOT_W-1:0] out_slot_o,
  output logic [CH_W-1:0]   out_chan_o,
  output logic [CHG_W-1:0]  out_charge_o,
  output logic [TIM_W-1:0]  out_time_o,
  output logic              out_last_o,
  output logic [BYTE_W-1:0] out_bytes_o
);
  localparam int CNT_W = $clog2(N_CH + 1);

  scan_state_e       state_q;
  logic [SLOT_W-1:0] slot_q;
  logic [CH_W-1:0]   ch_q, last_q;
  logic [CNT_W-1:0]  kept_q;
  logic [CHG_W-1:0]  charge_q;
  logic [TIM_W-1:0]  time_q;
  logic              at_last;

  assign at_last = (ch_q == last_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      slot_q   <= '0;
      ch_q     <= '0;
      last_q   <= '0;
      kept_q   <= '0;
      charge_q <= '0;
      time_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          slot_q  <= slot_i;
          last_q  <= last_i;
          ch_q    <= '0;
          kept_q  <= '0;
          state_q <= any_i ? ST_CONV : ST_TRAIL;
        end
        ST_CONV: if (conv_done_i) begin
          charge_q <= conv_charge_i;
          time_q   <= conv_time_i;
          if (conv_charge_i >= thr_i) begin
            kept_q  <= kept_q + 1'b1;
            state_q <= ST_EMIT;
          end else if (at_last) begin
            state_q <= ST_TRAIL;
          end else begin
            ch_q <= ch_q + 1'b1;
          end
        end
        ST_EMIT: if (out_ready_i) begin
          if (at_last) state_q <= ST_TRAIL;
          else begin
            ch_q    <= ch_q + 1'b1;
            state_q <= ST_CONV;
          end
        end
        ST_TRAIL: if (out_ready_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o       = (state_q != ST_IDLE);
  assign conv_req_o   = (state_q == ST_CONV);
  assign conv_slot_o  = slot_q;
  assign conv_chan_o  = ch_q;
  assign out_valid_o  = (state_q == ST_EMIT) || (state_q == ST_TRAIL);
  assign out_last_o   = (state_q == ST_TRAIL);
  assign out_slot_o   = slot_q;
  assign out_chan_o   = (state_q == ST_EMIT) ? ch_q : '0;
  assign out_charge_o = (state_q == ST_EMIT) ? charge_q : '0;
  assign out_time_o   = (state_q == ST_EMIT) ? time_q : '0;
  assign out_bytes_o  = out_last_o ? BYTE_W'(kept_q) * BYTE_W'(BPH) : '0;

  // R5
  chan_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_req_o |-> conv_chan_o <= last_q);
  // R9
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o &&
      $stable({out_slot_o, out_chan_o, out_charge_o, out_time_o, out_last_o, out_bytes_o}));
  // R8
  trail_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i && out_last_o |=> !out_valid_o);
  // R5
  req_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_req_o && !conv_done_i |=> conv_req_o && $stable(conv_chan_o));
endmodule

// File: rtl/digi_sched.sv
module digi_sched #(
  parameter int N_CH   = 8,
  parameter int SLOT_W = 5,
  parameter int CHG_W  = 8,
  parameter int TIM_W  = 8,
  parameter int DEPTH  = 4,
  localparam int CH_W   = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam int BPH    = (CHG_W + 7) / 8 + (TIM_W + 7) / 8,
  localparam int BYTE_W = $clog2(N_CH * BPH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_i,
  input  logic [SLOT_W-1:0] trig_slot_i,
  input  logic [N_CH-1:0]   trig_hits_i,
  input  logic [CHG_W-1:0]  thr_i,
  output logic              conv_req_o,
  output logic [SLOT_W-1:0] conv_slot_o,
  output logic [CH_W-1:0]   conv_chan_o,
  input  logic              conv_done_i,
  input  logic [CHG_W-1:0]  conv_charge_i,
  input  logic [TIM_W-1:0]  conv_time_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [SLOT_W-1:0] out_slot_o,
  output logic [CH_W-1:0]   out_chan_o,
  output logic [CHG_W-1:0]  out_charge_o,
  output logic [TIM_W-1:0]  out_time_o,
  output logic              out_last_o,
  output logic [BYTE_W-1:0] out_bytes_o,
  output logic              overflow_o
);
  localparam int ENT_W = SLOT_W + N_CH;

  logic             busy, empty, full, push, pop, start, defer, ovf_q;
  logic [ENT_W-1:0] head;
  logic [SLOT_W-1:0] start_slot;
  logic [N_CH-1:0]  start_hits;
  logic             start_any;
  logic [CH_W-1:0]  start_last;

  // pending events wait if a scan runs or older ones are queued
  assign defer = busy || !empty;
  assign pop   = !busy && !empty;
  assign start = !busy && (!empty || trig_i);
  assign push  = trig_i && defer && (!full || pop);

  assign {start_slot, start_hits} = empty ? {trig_slot_i, trig_hits_i} : head;

  pend_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i (push),
    .pop_i  (pop),
    .din_i  ({trig_slot_i, trig_hits_i}),
    .dout_o (head),
    .empty_o(empty),
    .full_o (full)
  );

  last_hit #(.N_CH(N_CH), .CH_W(CH_W)) u_last (
    .hits_i(start_hits),
    .any_o (start_any),
    .last_o(start_last)
  );

  scan_ctrl #(
    .N_CH(N_CH), .CH_W(CH_W), .SLOT_W(SLOT_W), .CHG_W(CHG_W),
    .TIM_W(TIM_W), .BYTE_W(BYTE_W), .BPH(BPH)
  ) u_scan (
    .clk_i, .rst_ni,
    .start_i      (start),
    .slot_i       (start_slot),
    .any_i        (start_any),
    .last_i       (start_last),
    .thr_i,
    .busy_o       (busy),
    .conv_req_o, .conv_slot_o, .conv_chan_o,
    .conv_done_i, .conv_charge_i, .conv_time_i,
    .out_valid_o, .out_ready_i, .out_slot_o, .out_chan_o,
    .out_charge_o, .out_time_o, .out_last_o, .out_bytes_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           ovf_q <= 1'b0;
    else if (trig_i && defer && full && !pop) ovf_q <= 1'b1;
  end
  assign overflow_o = ovf_q;

  // R1
  start_now_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i && !busy && empty |=> busy && (conv_slot_o == $past(trig_slot_i)));
  // R4
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);
  // R4
  ovf_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overflow_o) |-> $past(trig_i) && $past(full));
endmodule

// File: tb/digi_sched_tb.sv
module digi_sched_tb;
  localparam int N_CH = 8, SLOT_W = 5, CHG_W = 8, TIM_W = 8;
  localparam int CH_W = 3, BYTE_W = 5;
  localparam int WW = SLOT_W + 1 + CH_W + CHG_W + TIM_W + BYTE_W;

  logic clk_i = 0, rst_ni = 0;
  logic trig_i = 0;
  logic [SLOT_W-1:0] trig_slot_i = '0;
  logic [N_CH-1:0] trig_hits_i = '0;
  logic [CHG_W-1:0] thr_i = '0;
  logic conv_req_o, conv_done_i = 0;
  logic [SLOT_W-1:0] conv_slot_o;
  logic [CH_W-1:0] conv_chan_o;
  logic [CHG_W-1:0] conv_charge_i = '0;
  logic [TIM_W-1:0] conv_time_i = '0;
  logic out_valid_o, out_ready_i = 0, out_last_o, overflow_o;
  logic [SLOT_W-1:0] out_slot_o;
  logic [CH_W-1:0] out_chan_o;
  logic [CHG_W-1:0] out_charge_o;
  logic [TIM_W-1:0] out_time_o;
  logic [BYTE_W-1:0] out_bytes_o;

  int checks = 0, fails = 0, cwait = 0;
  bit hold_ready = 0, stall_q = 0;
  logic [WW-1:0] held;
  logic [WW-1:0] exp_q [$];
  logic [SLOT_W+CH_W-1:0] conv_q [$];

  always #2 clk_i = ~clk_i;

  digi_sched u_dut (.*);

  function automatic logic [CHG_W-1:0] chg_fn(int s, int c);
    return CHG_W'(s * 37 + c * 53 + 19);
  endfunction
  function automatic logic [TIM_W-1:0] tim_fn(int s, int c);
    return TIM_W'(s * 11 + c * 29 + 7);
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // predicted words and conversions for one accepted event
  task automatic add_event(int s, logic [N_CH-1:0] m);
    int last = -1, kept = 0;
    for (int i = 0; i < N_CH; i++) if (m[i]) last = i;
    for (int c = 0; c <= last; c++) begin
      conv_q.push_back({SLOT_W'(s), CH_W'(c)});
      if (chg_fn(s, c) >= thr_i) begin
        exp_q.push_back({SLOT_W'(s), 1'b0, CH_W'(c), chg_fn(s, c), tim_fn(s, c), BYTE_W'(0)});
        kept++;
      end
    end
    exp_q.push_back({SLOT_W'(s), 1'b1, CH_W'(0), CHG_W'(0), TIM_W'(0), BYTE_W'(kept * 2)});
  endtask

  // converter model
  always @(negedge clk_i) begin
    if (!rst_ni) conv_done_i = 0;
    else if (conv_done_i) begin
      conv_done_i = 0;
      cwait = $urandom_range(0, 3);
    end else if (conv_req_o) begin
      if (cwait == 0) begin
        if (conv_q.size() == 0)
          check(0, "R5 unexpected conversion", {conv_slot_o, conv_chan_o}, 0);
        else begin
          logic [SLOT_W+CH_W-1:0] e;
          e = conv_q.pop_front();
          check({conv_slot_o, conv_chan_o} == e, "R5 R3 conversion order", {conv_slot_o, conv_chan_o}, e);
        end
        conv_charge_i = chg_fn(conv_slot_o, conv_chan_o);
        conv_time_i   = tim_fn(conv_slot_o, conv_chan_o);
        conv_done_i   = 1;
      end else cwait--;
    end
  end

  // output monitor
  always @(negedge clk_i) begin
    if (rst_ni) begin
      logic [WW-1:0] cur;
      cur = {out_slot_o, out_last_o, out_chan_o, out_charge_o, out_time_o, out_bytes_o};
      if (stall_q)
        check(out_valid_o && cur == held, "R9 stalled word held", cur, held);
      out_ready_i = hold_ready ? 1'b0 : ($urandom_range(0, 3) != 0);
      if (out_valid_o && out_ready_i) begin
        if (exp_q.size() == 0) check(0, "R3 unexpected word", cur, 0);
        else begin
          logic [WW-1:0] e;
          e = exp_q.pop_front();
          check(cur == e, "R3 R6 R7 R8 output word", cur, e);
        end
      end
      stall_q = out_valid_o && !out_ready_i;
      held = cur;
    end else stall_q = 0;
  end

  task automatic fire(int s, logic [N_CH-1:0] m, bit accept);
    @(negedge clk_i);
    trig_i = 1; trig_slot_i = SLOT_W'(s); trig_hits_i = m;
    if (accept) add_event(s, m);
  endtask

  task automatic idle_trig();
    @(negedge clk_i); trig_i = 0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || conv_q.size() != 0) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    check(0, "watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd5521));
    repeat (3) @(negedge clk_i);
    // R10 reset state
    check(!out_valid_o && !conv_req_o && !overflow_o, "R10 reset outputs",
          {out_valid_o, conv_req_o, overflow_o}, 0);
    rst_ni = 1;
    repeat (2) @(negedge clk_i);

    // R1 immediate start
    thr_i = 8'd100;
    fire(9, 8'h04, 1);
    @(negedge clk_i); trig_i = 0;
    check(conv_req_o && conv_slot_o == 9 && conv_chan_o == 0, "R1 immediate start",
          {conv_req_o, conv_slot_o, conv_chan_o}, {1'b1, 5'd9, 3'd0});
    drain();

    // R8 empty mask: trailer only
    fire(4, 8'h00, 1); idle_trig(); drain();

    // R6 equality boundary: kept, then dropped one above
    thr_i = chg_fn(3, 2);
    fire(3, 8'h04, 1); idle_trig(); drain();
    thr_i = chg_fn(3, 2) + 1;
    fire(3, 8'h04, 1); idle_trig(); drain();
    thr_i = 0;
    fire(17, 8'h80, 1); idle_trig(); drain();

    // R2 fill buffer exactly while output stalled
    thr_i = 8'd90;
    hold_ready = 1;
    for (int i = 0; i < 5; i++) fire(i + 20, 8'(8'h11 << (i % 4)), 1);
    idle_trig();
    repeat (10) @(negedge clk_i);
    check(!overflow_o, "R2 five triggers fit", overflow_o, 0);
    hold_ready = 0;
    drain();

    // random bursts
    for (int b = 0; b < 30; b++) begin
      int n;
      thr_i = CHG_W'($urandom_range(0, 255));
      n = $urandom_range(1, 5);
      for (int k = 0; k < n; k++) begin
        fire($urandom_range(0, 31), ($urandom_range(0, 5) == 0) ? 8'h00 : N_CH'($urandom), 1);
        if ($urandom_range(0, 1) == 1) begin
          idle_trig();
          repeat ($urandom_range(0, 12)) @(negedge clk_i);
        end
      end
      idle_trig();
      drain();
    end
    check(!overflow_o, "R4 no overflow in bounded bursts", overflow_o, 0);

    // R4 overflow: seven back-to-back, two dropped
    thr_i = 8'd60;
    hold_ready = 1;
    for (int i = 0; i < 7; i++) fire(i + 1, 8'h22, i < 5);
    idle_trig();
    check(overflow_o, "R4 overflow set", overflow_o, 1);
    hold_ready = 0;
    drain();
    check(overflow_o, "R4 overflow sticky", overflow_o, 1);

    // R10 reset clears flag
    @(negedge clk_i); rst_ni = 0;
    @(negedge clk_i);
    check(!out_valid_o && !conv_req_o && !overflow_o, "R10 reset clears",
          {out_valid_o, conv_req_o, overflow_o}, 0);
    rst_ni = 1;
    repeat (2) @(negedge clk_i);
    summary();
    $finish;
  end
endmodule